// File: doc/BRIEF.md
# Partial-Word Store Lane Generator

This block sits between a core's store pipeline and the memory write port. It turns a request to store part of a register into one aligned write command. A request carries a variant flag, a byte address and a 32-bit source word. Each command carries a word address, byte enables, lane-positioned data and a flag that marks a probe-only cycle. Memory is big-endian. Byte 0 of a word is the most significant lane.

The two variants split a word at the addressed byte. The begin variant covers the span from the addressed byte to the last byte of the word. The end variant covers the bytes in front of the addressed byte. For both variants the source word passes to the lanes without a shift, so the enabled lanes carry the right source bytes. The begin variant keeps the low-order source bytes and the end variant keeps the high-order ones. Disabled lanes carry zero.

The block accepts a request through a valid/ready handshake. It places exactly one command in a registered output slot, which drains through its own valid/ready handshake. A three-byte store therefore reaches memory as a single masked write and is never split. An end-variant store at offset zero enables no bytes. It still produces a command, flagged as probe-only, so that the write-permission check and the dirty marking take place downstream.

Top module: `edge_store_lanes`

## Requirements
- R1: During and directly after reset, `cmd_valid` is 0 and `req_ready` is 1.
- R2: Begin variant (`req_is_end`=0), with offset o = `req_addr[1:0]`: byte k of the word is enabled when k >= o. `cmd_be` bit 3 belongs to byte 0 and bit 0 to byte 3, so offsets 0/1/2/3 give 1111/0111/0011/0001.
- R3: End variant (`req_is_end`=1): byte k is enabled when k < o, so offsets 0/1/2/3 give 0000/1000/1100/1110.
- R4: `cmd_data` equals `req_data` in every enabled lane and is zero in every disabled lane. Byte 0 of the word is `cmd_data[31:24]`.
- R5: A three-byte store (begin at offset 1, end at offset 3) is issued as one command with enables 0111 or 1110 respectively.
- R6: `cmd_probe_only` is 1 exactly for an end-variant store at offset 0. Such a command has `cmd_be`=0000 and `cmd_data`=0.
- R7: `cmd_word_addr` equals `req_addr[31:2]`.
- R8: `req_ready` = !`cmd_valid` || `cmd_ready`. A request accepted on an edge shows up as `cmd_valid`=1 after that same edge. Each request yields exactly one command.
- R9: While `cmd_valid`=1 and `cmd_ready`=0, all command outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_is_end | input | 1 | 0 = begin variant, 1 = end variant |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Source word |
| cmd_valid | output | 1 | Write command present |
| cmd_ready | input | 1 | Memory takes the command |
| cmd_word_addr | output | 30 | Word address |
| cmd_be | output | 4 | Byte enables, bit 3 = byte 0 |
| cmd_data | output | 32 | Lane-positioned write data |
| cmd_probe_only | output | 1 | Command writes no bytes, probe and dirty only |

## Verification
The bench walks every offset of both variants. The three-byte cases matter most: a design that splits them or picks the wrong mask would write a stray lane or lose one. The zero-offset end store is checked for a command with no enables that still appears. A design that dropped it would silently skip the permission probe, and one that flagged it badly would write a whole word.

Long back-pressure stretches with a new request waiting test whether the output slot gets overwritten or the data changes under a stall. The reference model also catches a command issued twice or a cycle of added latency.

// File: rtl/esl_pkg.sv
package esl_pkg;
  typedef enum logic {
    KIND_BEGIN = 1'b0,
    KIND_END   = 1'b1
  } store_kind_e;
endpackage

// File: rtl/esl_lane_decode.sv
module esl_lane_decode #(
  parameter int NBYTES = 4,
  parameter int OFF_W  = 2
) (
  input  esl_pkg::store_kind_e kind,
  input  logic [OFF_W-1:0]     off,
  input  logic [NBYTES*8-1:0]  src,
  output logic [NBYTES-1:0]    be,
  output logic [NBYTES*8-1:0]  lanes,
  output logic                 probe
);
  localparam int DW = NBYTES * 8;

  // Byte idx (0 = most significant lane) lies inside the written span.
  function automatic logic lane_on(input logic is_end, input int o, input int idx);
    if (is_end) return idx < o;
    else        return idx >= o;
  endfunction

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic on;
    assign on                       = lane_on(kind == esl_pkg::KIND_END, int'(off), i);
    assign be[NBYTES-1-i]           = on;
    assign lanes[DW-1-8*i -: 8]     = on ? src[DW-1-8*i -: 8] : 8'h00;
  end

  assign probe = (kind == esl_pkg::KIND_END) && (off == '0);
endmodule

// File: rtl/esl_cmd_stage.sv
module esl_cmd_stage #(
  parameter int WAW    = 30,
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                drain,
  input  logic [WAW-1:0]      in_addr,
  input  logic [NBYTES-1:0]   in_be,
  input  logic [NBYTES*8-1:0] in_data,
  input  logic                in_probe,
  output logic                out_valid,
  output logic [WAW-1:0]      out_addr,
  output logic [NBYTES-1:0]   out_be,
  output logic [NBYTES*8-1:0] out_data,
  output logic                out_probe
);
  logic stalled;
  assign stalled = out_valid && !drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_be    <= '0;
      out_data  <= '0;
      out_probe <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_be    <= in_be;
      out_data  <= in_data;
      out_probe <= in_probe;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a stalled command holds every field
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> out_valid && $stable(out_addr) && $stable(out_be)
                && $stable(out_data) && $stable(out_probe));

  // R6: a probe-only command writes no lane
  a_r6_probe_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_probe |-> out_be == '0 && out_data == '0);
endmodule

// File: rtl/edge_store_lanes.sv
module edge_store_lanes #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_is_end,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_data,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] cmd_word_addr,
  output logic [DATA_W/8-1:0]        cmd_be,
  output logic [DATA_W-1:0]          cmd_data,
  output logic                       cmd_probe_only
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);
  localparam int WAW    = ADDR_W - OFF_W;

  esl_pkg::store_kind_e kind;
  logic [OFF_W-1:0]   off;
  logic [NBYTES-1:0]  dec_be;
  logic [DATA_W-1:0]  dec_lanes;
  logic               dec_probe;
  logic               accept;
  logic               retire;

  assign kind      = req_is_end ? esl_pkg::KIND_END : esl_pkg::KIND_BEGIN;
  assign off       = req_addr[OFF_W-1:0];
  assign req_ready = !cmd_valid || cmd_ready;
  assign accept    = req_valid && req_ready;
  assign retire    = cmd_valid && cmd_ready;

  esl_lane_decode #(.NBYTES(NBYTES), .OFF_W(OFF_W)) u_dec (
    .kind  (kind),
    .off   (off),
    .src   (req_data),
    .be    (dec_be),
    .lanes (dec_lanes),
    .probe (dec_probe)
  );

  esl_cmd_stage #(.WAW(WAW), .NBYTES(NBYTES)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .drain     (cmd_ready),
    .in_addr   (req_addr[ADDR_W-1:OFF_W]),
    .in_be     (dec_be),
    .in_data   (dec_lanes),
    .in_probe  (dec_probe),
    .out_valid (cmd_valid),
    .out_addr  (cmd_word_addr),
    .out_be    (cmd_be),
    .out_data  (cmd_data),
    .out_probe (cmd_probe_only)
  );

  // R8: an accepted request is visible on the next cycle
  a_r8_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cmd_valid);

  // R8: no command is retired without being replaced or cleared
  a_r8_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    retire && !req_valid |=> !cmd_valid);

  // R6: only probe-only commands may carry no enables
  a_r6_nonempty_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_probe_only |-> cmd_be != '0);

  // R3: enables form one contiguous span touching a word edge
  a_r3_edge_span: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_be & (cmd_be + 1'b1)) == '0)
               || (((~cmd_be) & ((~cmd_be) + 1'b1)) == '0));
endmodule

// File: tb/edge_store_lanes_test.sv
`timescale 1ns/1ps
module edge_store_lanes_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_end = 1'b0, cmd_ready = 1'b1;
  logic [31:0] req_addr = '0, req_data = '0;
  logic        req_ready, cmd_valid, cmd_probe_only;
  logic [29:0] cmd_word_addr;
  logic [3:0]  cmd_be;
  logic [31:0] cmd_data;

  edge_store_lanes uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_end(req_is_end), .req_addr(req_addr), .req_data(req_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word_addr(cmd_word_addr),
    .cmd_be(cmd_be), .cmd_data(cmd_data), .cmd_probe_only(cmd_probe_only));

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Reference rules, stated as shifts rather than per-lane tests
  function automatic logic [3:0] ref_be(input logic e, input logic [1:0] o);
    logic [3:0] tail = 4'b1111 >> o;
    return e ? ~tail : tail;
  endfunction
  function automatic logic [31:0] ref_data(input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return d & m;
  endfunction

  // Cycle-by-cycle model of the output slot
  logic        m_valid = 1'b0, m_probe = 1'b0;
  logic [29:0] m_addr = '0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_data = '0;
  wire m_ready = !m_valid || cmd_ready;
  bit  cmp_en = 0;

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (req_valid && m_ready) begin
      m_valid <= 1'b1;
      m_addr  <= req_addr[31:2];
      m_be    <= ref_be(req_is_end, req_addr[1:0]);
      m_data  <= ref_data(ref_be(req_is_end, req_addr[1:0]), req_data);
      m_probe <= req_is_end && (req_addr[1:0] == 2'd0);
    end else if (cmd_ready) m_valid <= 1'b0;
  end

  always @(negedge clk) begin
    cycles++;
    if (cmp_en && rst_n) begin
      chk(cmd_valid == m_valid, "R8", "model cmd_valid", 64'(cmd_valid), 64'(m_valid));
      chk(req_ready == m_ready, "R8", "model req_ready", 64'(req_ready), 64'(m_ready));
      if (m_valid && cmd_valid) begin
        chk(cmd_word_addr == m_addr, "R7", "model addr", 64'(cmd_word_addr), 64'(m_addr));
        chk(cmd_be == m_be, "R2/R3", "model be", 64'(cmd_be), 64'(m_be));
        chk(cmd_data == m_data, "R4", "model data", 64'(cmd_data), 64'(m_data));
        chk(cmd_probe_only == m_probe, "R6", "model probe", 64'(cmd_probe_only), 64'(m_probe));
      end
    end
  end

  task automatic put(input logic e, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_is_end = e; req_addr = a; req_data = d;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_cmd(input string rq, input logic [29:0] a, input logic [3:0] be,
                            input logic [31:0] d, input logic p);
    chk(cmd_valid === 1'b1, rq, "valid", 64'(cmd_valid), 64'd1);
    chk(cmd_word_addr === a, "R7", "word addr", 64'(cmd_word_addr), 64'(a));
    chk(cmd_be === be, rq, "be", 64'(cmd_be), 64'(be));
    chk(cmd_data === d, "R4", "data", 64'(cmd_data), 64'(d));
    chk(cmd_probe_only === p, "R6", "probe", 64'(cmd_probe_only), 64'(p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0, "R1", "valid in reset", 64'(cmd_valid), 64'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R1", "valid after reset", 64'(cmd_valid), 64'd0);
    chk(req_ready === 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    cmp_en = 1;

    // R2 begin variant, all offsets
    put(1'b0, 32'h0000_0100, 32'hA1B2_C3D4); expect_cmd("R2", 30'h40, 4'b1111, 32'hA1B2C3D4, 1'b0);
    put(1'b0, 32'h0000_0103, 32'hA1B2_C3D4); expect_cmd("R2", 30'h40, 4'b0001, 32'h000000D4, 1'b0);
    put(1'b0, 32'h0000_0102, 32'hA1B2_C3D4); expect_cmd("R2", 30'h40, 4'b0011, 32'h0000C3D4, 1'b0);
    put(1'b0, 32'h0000_0101, 32'hA1B2_C3D4); expect_cmd("R5", 30'h40, 4'b0111, 32'h00B2C3D4, 1'b0);
    // R3 end variant, all offsets
    put(1'b1, 32'h0000_0205, 32'hA1B2_C3D4); expect_cmd("R3", 30'h81, 4'b1000, 32'hA1000000, 1'b0);
    put(1'b1, 32'h0000_0206, 32'hA1B2_C3D4); expect_cmd("R3", 30'h81, 4'b1100, 32'hA1B20000, 1'b0);
    put(1'b1, 32'h0000_0207, 32'hA1B2_C3D4); expect_cmd("R5", 30'h81, 4'b1110, 32'hA1B2C300, 1'b0);
    put(1'b1, 32'h0000_020C, 32'hA1B2_C3D4); expect_cmd("R6", 30'h83, 4'b0000, 32'h00000000, 1'b1);
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R8", "single command", 64'(cmd_valid), 64'd0);

    // R9 stall with a second request waiting
    #1 cmd_ready = 1'b0;
    put(1'b0, 32'h0000_0300, 32'h1122_3344);
    #1 req_valid = 1'b1; req_is_end = 1'b1; req_addr = 32'h0000_0401; req_data = 32'h5566_7788;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cmd_data === 32'h11223344, "R9", "held data", 64'(cmd_data), 64'h11223344);
      chk(req_ready === 1'b0, "R8", "ready low in stall", 64'(req_ready), 64'd0);
    end
    #1 cmd_ready = 1'b1;
    @(negedge clk); #1 req_valid = 1'b0;
    expect_cmd("R3", 30'h100, 4'b1000, 32'h55000000, 1'b0);
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R8", "drained", 64'(cmd_valid), 64'd0);

    // Mixed traffic with random back-pressure, model compared each cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      req_valid  = ($urandom % 4) != 0;
      req_is_end = $urandom % 2;
      req_addr   = $urandom;
      req_data   = $urandom;
      cmd_ready  = ($urandom % 3) != 0;
    end
    @(negedge clk); #1 req_valid = 1'b0; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule